// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Arbiter

This block chooses one interrupt to present to a processor out of up to 54 request lines. Each line carries a pending flag and an enable flag, and has a 3-bit priority level that software programs through a small word-wide register file. Each 16-bit word holds four levels, one per nibble.

Arbitration has two tiers. The highest programmed level among the eligible requests wins. If several requests share that level, the line with the lowest source number wins. The arbiter reports the winner's source number as the vector, the winner's level, and a valid flag. It also compares the winner's level with the processor's current priority and raises an interrupt request only when the winner's level is strictly higher. The selection is combinational, and all results appear on registered outputs one clock later.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every implemented level field reads back as 4, and the valid, vector, level and request outputs are all 0.
- R2: Register word `w`, nibble `k`, bits `[4k+2:4k]`, holds the level of source `4w+k`. A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the word at `reg_addr` one clock after the address is applied.
- R3: Bit `4k+3` of every word is not stored. It ignores writes and always reads as 0.
- R4: A source is eligible only when its pending bit and its enable bit are both 1 and its level is not 0.
- R5: Among the eligible sources, one with a strictly higher level always wins, whatever its source number. For example, source 43 at level 7 beats source 0 at level 1.
- R6: Among eligible sources that share the highest level, the lowest source number wins.
- R7: `win_vec_o` equals the winning source number, and `win_lvl_o` equals that source's programmed level.
- R8: When no source is eligible, `win_vld_o`, `win_vec_o` and `win_lvl_o` are all 0.
- R9: `irq_req_o` is 1 exactly when a winner exists and its level is strictly greater than `cpu_lvl_i`.
- R10: The outputs show the arbitration of the inputs and levels present one clock earlier.
- R11: Nibbles that map to source numbers of 54 or above read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 54 | Pending flag per source |
| en_i | input | 54 | Enable flag per source |
| cpu_lvl_i | input | 3 | Current processor priority |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| win_vld_o | output | 1 | A winner exists |
| win_vec_o | output | 6 | Winning source number |
| win_lvl_o | output | 3 | Winning level |
| irq_req_o | output | 1 | Winner outranks the processor |

## Verification
The hardest case to reach is a tie at the top level among several sources, while higher-numbered sources sit at higher levels that are pending but masked. This is the only case that exercises both tiers and the eligibility mask at once. The stimulus first reprograms the level map through the register port, then drives crafted pending and enable patterns: a low-numbered source at a low level against a high-numbered source at level 7, and same-level pairs with a masked outranking line. After that it runs a long run of random pending, enable and processor-level patterns over a random level map. The bench's own level mirror and ranking loop predict every result.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants for the interrupt level arbiter.
// Assumes 3-bit levels packed one per 4-bit nibble in 16-bit words.
package irq_arb_pkg;
    localparam int LVL_W     = 3;
    localparam int NIB_W     = 4;
    localparam int WORD_W    = 16;
    localparam int NIB_PER_W = WORD_W / NIB_W;
    localparam logic [LVL_W-1:0] LVL_RESET = 3'd4;
endpackage

// File: rtl/irq_lvl_regs.sv
// Level register file: stores one level per source and packs four levels
// per word for software reads. Assumes the top bit of each nibble is not
// stored, and that nibbles beyond the last source are absent.
module irq_lvl_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 54,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    output logic [NUM_SRC*LVL_W-1:0] lvl_flat
);
    logic [WORD_W-1:0] rd_word;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int WRD = s / NIB_PER_W;
        localparam int NIB = s % NIB_PER_W;
        // Hold one source level; only its own nibble's low bits load it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_flat[s*LVL_W +: LVL_W] <= LVL_RESET;
            else if (we && (int'(addr) == WRD))
                lvl_flat[s*LVL_W +: LVL_W] <= wdata[NIB*NIB_W +: LVL_W];
        end
    end

    // Assemble the addressed word; unstored bits and absent sources read 0.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NIB_PER_W; k++) begin
            if (int'(addr) * NIB_PER_W + k < NUM_SRC)
                rd_word[k*NIB_W +: LVL_W] =
                    lvl_flat[(int'(addr) * NIB_PER_W + k) * LVL_W +: LVL_W];
        end
    end

    // Register the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_word;
    end
endmodule

// File: rtl/irq_lvl_select.sv
// Combinational winner search: the highest level wins, and ties go to the
// lowest index. Assumes level 0 is never eligible.
module irq_lvl_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 54,
    parameter int VEC_W   = 6
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
    output logic                     found,
    output logic [VEC_W-1:0]         vec,
    output logic [LVL_W-1:0]         lvl
);
    // Scan from the top index down; ">=" lets lower indices take ties.
    always_comb begin
        found = 1'b0;
        vec   = '0;
        lvl   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (lvl_flat[i*LVL_W +: LVL_W] != '0) &&
                (!found || lvl_flat[i*LVL_W +: LVL_W] >= lvl)) begin
                found = 1'b1;
                vec   = VEC_W'(i);
                lvl   = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irq_level_arbiter.sv
// Top: masks requests with enables, picks a winner over programmed levels,
// registers the result and compares it with the processor priority.
// Assumes a synchronous active-low reset and a single clock domain.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 54,
    localparam int NUM_WORDS = (NUM_SRC + NIB_PER_W - 1) / NIB_PER_W,
    localparam int ADDR_W    = $clog2(NUM_WORDS),
    localparam int VEC_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [LVL_W-1:0]   cpu_lvl_i,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               win_vld_o,
    output logic [VEC_W-1:0]   win_vec_o,
    output logic [LVL_W-1:0]   win_lvl_o,
    output logic               irq_req_o
);
    logic [NUM_SRC*LVL_W-1:0] lvl_flat;
    logic                     sel_found;
    logic [VEC_W-1:0]         sel_vec;
    logic [LVL_W-1:0]         sel_lvl;

    irq_lvl_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .lvl_flat (lvl_flat)
    );

    irq_lvl_select #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_sel (
        .req      (pend_i & en_i),
        .lvl_flat (lvl_flat),
        .found    (sel_found),
        .vec      (sel_vec),
        .lvl      (sel_lvl)
    );

    // Register the winner and the request decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_vld_o <= 1'b0;
            win_vec_o <= '0;
            win_lvl_o <= '0;
            irq_req_o <= 1'b0;
        end else begin
            win_vld_o <= sel_found;
            win_vec_o <= sel_vec;
            win_lvl_o <= sel_lvl;
            irq_req_o <= sel_found && (sel_lvl > cpu_lvl_i);
        end
    end
endmodule

// File: rtl/irq_arb_checker.sv
// Checker: properties on the arbiter's ports, attached by bind.
module irq_arb_checker
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 54,
    parameter int VEC_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic [LVL_W-1:0]   cpu_lvl_i,
    input logic [WORD_W-1:0]  reg_rdata,
    input logic               win_vld_o,
    input logic [VEC_W-1:0]   win_vec_o,
    input logic [LVL_W-1:0]   win_lvl_o,
    input logic               irq_req_o
);
    logic [NUM_SRC-1:0] elig_q;
    // Keep the previous cycle's pending-and-enabled set.
    always_ff @(posedge clk) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= pend_i & en_i;
    end

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !win_vld_o |-> (win_vec_o == '0 && win_lvl_o == '0 && !irq_req_o));
    a_r9_strict_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (win_lvl_o > $past(cpu_lvl_i)));
    a_r9_request_when_above: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld_o && win_lvl_o > $past(cpu_lvl_i)) |-> irq_req_o);
    a_r4_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> (win_lvl_o != '0));
    a_r4_winner_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> (int'(win_vec_o) < NUM_SRC && elig_q[win_vec_o]));
    a_r3_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 16'h8888) == 16'h0000);
endmodule

bind irq_level_arbiter irq_arb_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend_i),
    .en_i      (en_i),
    .cpu_lvl_i (cpu_lvl_i),
    .reg_rdata (reg_rdata),
    .win_vld_o (win_vld_o),
    .win_vec_o (win_vec_o),
    .win_lvl_o (win_lvl_o),
    .irq_req_o (irq_req_o)
);

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
    localparam int N = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend_i = '0;
    logic [N-1:0]  en_i = '0;
    logic [2:0]    cpu_lvl_i = '0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          win_vld_o;
    logic [5:0]    win_vec_o;
    logic [2:0]    win_lvl_o;
    logic          irq_req_o;

    int checks = 0;
    int fails  = 0;
    logic [2:0] lvl_m [N];

    typedef struct {
        logic       vld;
        logic [5:0] vec;
        logic [2:0] lvl;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    irq_level_arbiter u_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .cpu_lvl_i(cpu_lvl_i), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_vld_o(win_vld_o),
        .win_vec_o(win_vec_o), .win_lvl_o(win_lvl_o), .irq_req_o(irq_req_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference ranking: walk levels from 7 down, sources from 0 up.
    function automatic exp_t model(input logic [N-1:0] p, input logic [N-1:0] e,
                                   input logic [2:0] cpu, input string tag);
        exp_t r;
        r.vld = 0; r.vec = 0; r.lvl = 0; r.irq = 0; r.tag = tag;
        for (int l = 7; l >= 1 && !r.vld; l--)
            for (int s = 0; s < N && !r.vld; s++)
                if (p[s] && e[s] && int'(lvl_m[s]) == l) begin
                    r.vld = 1; r.vec = 6'(s); r.lvl = 3'(l);
                end
        r.irq = r.vld && (r.lvl > cpu);
        return r;
    endfunction

    // Driver: apply one pattern for one cycle and queue its expected result.
    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [2:0] cpu, input string tag);
        @(negedge clk);
        pend_i = p; en_i = e; cpu_lvl_i = cpu;
        sb.push_back(model(p, e, cpu, tag));
    endtask

    // Monitor: results appear after the edge that follows the drive.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            check({x.tag, " R10 vld"}, 32'(win_vld_o), 32'(x.vld));
            check({x.tag, " R7 vec"},  32'(win_vec_o), 32'(x.vec));
            check({x.tag, " R7 lvl"},  32'(win_lvl_o), 32'(x.lvl));
            check({x.tag, " R9 irq"},  32'(irq_req_o), 32'(x.irq));
        end
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
        for (int k = 0; k < 4; k++)
            if (a * 4 + k < N) lvl_m[a*4+k] = d[k*4 +: 3];
        @(negedge clk);
        reg_we = 0;
    endtask

    function automatic logic [15:0] word_m(input int a);
        logic [15:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (a * 4 + k < N) w[k*4 +: 3] = lvl_m[a*4+k];
        return w;
    endfunction

    task automatic rd_check(input int a, input string tag);
        @(negedge clk);
        reg_addr = 4'(a);
        @(posedge clk); #2;
        check(tag, 32'(reg_rdata), 32'(word_m(a)));
    endtask

    task automatic set_lvl(input int s, input logic [2:0] l);
        logic [15:0] w;
        lvl_m[s] = l;
        w = word_m(s / 4);
        wr(s / 4, w);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] one;
        for (int s = 0; s < N; s++) lvl_m[s] = 3'd4;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of the outputs and the level fields.
        @(posedge clk); #2;
        check("R1 vld", 32'(win_vld_o), 0);
        check("R1 vec", 32'(win_vec_o), 0);
        check("R1 irq", 32'(irq_req_o), 0);
        for (int a = 0; a < 14; a++) rd_check(a, "R1 R2 reset word");
        // R3, R11: write all ones, top bits and absent nibbles stay 0.
        wr(13, 16'hFFFF);
        rd_check(13, "R3 R11 last word");
        @(negedge clk); reg_addr = 4'd13;
        @(posedge clk); #2;
        check("R11 absent nibbles", 32'(reg_rdata), 32'h0077);
        wr(0, 16'hFFFF);
        @(negedge clk); reg_addr = 4'd0;
        @(posedge clk); #2;
        check("R3 word0 ones", 32'(reg_rdata), 32'h7777);
        wr(0, 16'h4444);
        wr(13, 16'h0044);
        // R2: distinct levels in one word land on the right sources.
        wr(2, 16'h3172);
        rd_check(2, "R2 word2");
        one = '0; one[9] = 1;
        apply(one, one, 3'd0, "R2 source9 level7");
        // R4: pending without enable, and level 0.
        apply(one, '0, 3'd0, "R4 masked");
        set_lvl(9, 3'd0);
        apply(one, one, 3'd0, "R4 level0");
        apply('0, '1, 3'd0, "R8 nothing pending");
        // R5: source 43 at level 7 beats source 0 at level 1.
        set_lvl(43, 3'd7); set_lvl(0, 3'd1);
        one = '0; one[43] = 1; one[0] = 1;
        apply(one, '1, 3'd0, "R5 level beats index");
        // R6: tie at level 5 between 5 and 20, while 43 is pending but masked.
        set_lvl(5, 3'd5); set_lvl(20, 3'd5);
        one = '0; one[5] = 1; one[20] = 1; one[43] = 1;
        apply(one, ~(54'd1 << 43), 3'd0, "R6 tie low index");
        // R9: processor level equal, then one below.
        apply(one, ~(54'd1 << 43), 3'd5, "R9 equal no irq");
        apply(one, ~(54'd1 << 43), 3'd4, "R9 one below");
        apply(one, ~(54'd1 << 43), 3'd7, "R9 cpu top");
        // R10: back-to-back changes are tracked cycle by cycle.
        apply('1, '1, 3'd6, "R10 all pending");
        apply('0, '0, 3'd0, "R10 then none");
        // Random level map and patterns.
        for (int a = 0; a < 14; a++) wr(a, 16'($urandom));
        for (int i = 0; i < 400; i++)
            apply({$urandom, $urandom} & {$urandom, $urandom},
                  {$urandom, $urandom} | {$urandom, $urandom},
                  3'($urandom), "R5 R6 random");
        for (int a = 0; a < 14; a++) rd_check(a, "R2 R3 random word");
        apply('0, '0, 3'd0, "R8 final idle");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule